// File: doc/BRIEF.md
# Asynchronous NAND bus sequencer

This block runs the byte-wide bus of a single NAND flash device that has no clock of its own. A host-side request gives one opcode byte, zero or more address bytes and a byte count with a direction. The block turns that request into the strobe waveforms the device needs. The opcode goes out first, with the command qualifier raised. The address bytes follow, with the address qualifier raised. The block then waits a programmable settle delay and holds until the device reports ready. Only after that does it move the data, one byte per write pulse or per read pulse.

Every strobe is built from the local clock. Its low time and its high time are each a count of clock cycles taken from configuration inputs, and the smallest count is one. The device select stays asserted for the whole request. The byte bus is driven only while bytes go towards the device. The write-protect output is released only for requests marked as program or erase. A one-cycle completion pulse ends each request, and the block is then ready for the next one.

Top module: `nandbus_seq`

## Requirements
- R1: `fl_sel_n` is 0 from the cycle after a request is accepted until the completion pulse. It is 1 whenever `req_ready` is 1. After reset, and after any reset in the middle of a request, the block is idle: `req_ready`=1, `fl_sel_n`=1, both strobes are 1 and `fl_doe`=0.
- R2: Each request first produces one write pulse with `fl_cmd_lat`=1 carrying `req_cmd`. It then produces `req_addr_cnt` write pulses with `fl_adr_lat`=1, carrying `req_addr[7:0]` first and then each higher byte in turn. The two qualifiers are never 1 together, and data pulses carry neither of them.
- R3: While `fl_wr_stb_n` is low, and in the cycle in which it rises, `fl_dout` and both qualifiers keep their values.
- R4: With `req_rd`=0 and `req_len`=N, the block issues N data write pulses. Each pulse carries the `wr_data` value present in the cycle where `wr_take` is 1, and `wr_take` is 1 exactly once per data byte.
- R5: With `req_rd`=1 and `req_len`=N, the block issues N read pulses on `fl_rd_stb_n`. For each pulse, `rd_valid` is 1 for one cycle and `rd_data` holds the value of `fl_din` sampled in the last low cycle of that pulse. The write strobe and the read strobe are never low together.
- R6: `fl_doe` is 1 during every write pulse and 0 during every read pulse. A read pulse never coincides with a raised qualifier.
- R7: After the last opcode or address pulse, the block waits max(`cfg_wait`,1) cycles. It then waits until `fl_ready` (1 = ready), passed through a two-stage synchronizer, reads 1. Only then does it issue any data pulse, or the completion pulse when `req_len`=0.
- R8: `fl_lock_n` (0 = protected) is 1 only while a request accepted with `req_prog`=1 is in progress, and is 0 at all other times.
- R9: Every strobe pulse stays low for exactly max(`cfg_low`,1) cycles. Between consecutive pulses of one request, the strobes stay high for at least max(`cfg_high`,1) cycles.
- R10: `done` is a one-cycle pulse and coincides with `req_ready`=1. A `req_valid` raised while a request is in progress is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| req_valid | input | 1 | request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | block idle, able to accept a request |
| req_cmd | input | 8 | opcode byte |
| req_addr_cnt | input | 3 | number of address bytes (0 to MAX_ADDR) |
| req_addr | input | 40 | address bytes, lowest byte sent first |
| req_len | input | 12 | number of data bytes |
| req_rd | input | 1 | 1 = data read from device, 0 = data write |
| req_prog | input | 1 | 1 = program/erase request, lifts write protect |
| cfg_low | input | 4 | strobe low time in cycles (0 treated as 1) |
| cfg_high | input | 4 | strobe high time in cycles (0 treated as 1) |
| cfg_wait | input | 4 | settle delay before ready sampling (0 treated as 1) |
| wr_data | input | 8 | current write data byte |
| wr_take | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 8 | byte read from device |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | request finished |
| fl_sel_n | output | 1 | device select, active low |
| fl_cmd_lat | output | 1 | current write pulse carries an opcode |
| fl_adr_lat | output | 1 | current write pulse carries an address byte |
| fl_wr_stb_n | output | 1 | write strobe, device latches on its rising edge |
| fl_rd_stb_n | output | 1 | read strobe, one byte per pulse |
| fl_lock_n | output | 1 | write protect, active low |
| fl_dout | output | 8 | byte bus value towards device |
| fl_doe | output | 1 | byte bus output enable |
| fl_din | input | 8 | byte bus value from device |
| fl_ready | input | 1 | device ready (0 = busy) |

## Verification
Five requests are replayed against a behavioural device model. They are: a bare opcode, an opcode with one address byte and a four-byte read, a five-address six-byte program, a three-address erase with no data and zero timing settings, and a five-address read with a long high time. Together they separate the ordering of opcode, address and data, the handling of zero counts against the minimum of one, and the two data directions. The model pulls its ready line low after every opcode or address byte for longer than any settle delay. A design that ignored the ready line would therefore issue data, or finish, while the model is still busy. A request poked in the middle of a transfer and a reset in the middle of a read show whether stray inputs leak into the bus sequence.

// File: rtl/nbs_pkg.sv
// Shared types for the NAND bus sequencer.
// Assumes: nothing beyond SystemVerilog-2017 enums.
package nbs_pkg;

    // Request sequencing phases, in the order a request walks through them.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_ADDR,
        SQ_DLY,
        SQ_RDY,
        SQ_DATA,
        SQ_FIN
    } sq_state_t;

    // Phases of one strobe pulse.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } pulse_ph_t;

endpackage

// File: rtl/nbs_pulse_gen.sv
// One strobe pulse: low for max(low_cyc,1) cycles, then high for
// max(high_cyc,1) cycles. 'sample' marks the last low cycle and 'done'
// marks the last high cycle.
// Assumes: start is raised only while the generator is idle.
module nbs_pulse_gen
    import nbs_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] low_cyc,
    input  logic [TW-1:0] high_cyc,
    output logic          stb_low,
    output logic          sample,
    output logic          done
);

    pulse_ph_t     ph;
    logic [TW-1:0] cnt;
    logic [TW-1:0] lo_ld;
    logic [TW-1:0] hi_ld;

    // Reload values, with zero treated as one cycle.
    assign lo_ld = (low_cyc  == '0) ? '0 : low_cyc  - 1'b1;
    assign hi_ld = (high_cyc == '0) ? '0 : high_cyc - 1'b1;

    // Walk through the low and high phases of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph  <= PH_LOW;
                        cnt <= lo_ld;
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        ph  <= PH_HIGH;
                        cnt <= hi_ld;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) ph <= PH_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign stb_low = (ph == PH_LOW);
    assign sample  = (ph == PH_LOW)  && (cnt == '0);
    assign done    = (ph == PH_HIGH) && (cnt == '0);

endmodule

// File: rtl/nbs_delay.sv
// Settle timer: after a start pulse, 'expired' rises in the
// max(dly,1)-th following cycle for one cycle.
// Assumes: start is raised only while the timer is not running.
module nbs_delay #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] dly,
    output logic          expired
);

    logic          run;
    logic [TW-1:0] cnt;

    // Count the delay down once started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= (dly == '0) ? '0 : dly - 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

endmodule

// File: rtl/nandbus_seq.sv
// Request sequencer for one 8-bit asynchronous NAND device.
// It issues the opcode pulse, then the address pulses, then a settle
// delay and a wait for ready, then the data pulses.
// Assumes: fl_din is stable by the last low cycle of a read pulse, and
// fl_ready is asynchronous and is synchronized here.
module nandbus_seq
    import nbs_pkg::*;
#(
    parameter int MAX_ADDR    = 5,
    parameter int LEN_W       = 12,
    parameter int TW          = 4,
    parameter int SYNC_STAGES = 2,
    localparam int ACW        = $clog2(MAX_ADDR + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [7:0]            req_cmd,
    input  logic [ACW-1:0]        req_addr_cnt,
    input  logic [MAX_ADDR*8-1:0] req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_rd,
    input  logic                  req_prog,
    input  logic [TW-1:0]         cfg_low,
    input  logic [TW-1:0]         cfg_high,
    input  logic [TW-1:0]         cfg_wait,
    input  logic [7:0]            wr_data,
    output logic                  wr_take,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    output logic                  done,
    output logic                  fl_sel_n,
    output logic                  fl_cmd_lat,
    output logic                  fl_adr_lat,
    output logic                  fl_wr_stb_n,
    output logic                  fl_rd_stb_n,
    output logic                  fl_lock_n,
    output logic [7:0]            fl_dout,
    output logic                  fl_doe,
    input  logic [7:0]            fl_din,
    input  logic                  fl_ready
);

    sq_state_t             st;
    logic                  issued;
    logic [7:0]            cmd_q;
    logic [MAX_ADDR*8-1:0] addr_q;
    logic [ACW-1:0]        acnt_q;
    logic [ACW-1:0]        aidx;
    logic [LEN_W-1:0]      len_q;
    logic [LEN_W-1:0]      dcnt;
    logic                  rd_q;
    logic                  prog_q;
    logic [7:0]            dout_q;
    logic [7:0]            byte_sel;
    logic [SYNC_STAGES-1:0] rdy_sh;
    logic                  ready_s;
    logic                  pg_start, pg_low, pg_sample, pg_done;
    logic                  dl_start, dl_exp;
    logic                  rd_phase;

    // Bring the asynchronous ready line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_sh <= '0;
        else        rdy_sh <= {rdy_sh[SYNC_STAGES-2:0], fl_ready};
    end
    assign ready_s = rdy_sh[SYNC_STAGES-1];

    assign rd_phase = (st == SQ_DATA) && rd_q;
    assign pg_start = !issued && ((st == SQ_CMD) || (st == SQ_ADDR) || (st == SQ_DATA));
    assign dl_start = !issued && (st == SQ_DLY);
    assign wr_take  = pg_start && (st == SQ_DATA) && !rd_q;

    // Pick the byte that the next write pulse carries.
    always_comb begin
        case (st)
            SQ_ADDR: byte_sel = addr_q[{aidx, 3'b000} +: 8];
            SQ_DATA: byte_sel = wr_data;
            default: byte_sel = cmd_q;
        endcase
    end

    nbs_pulse_gen #(.TW(TW)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pg_start),
        .low_cyc  (cfg_low),
        .high_cyc (cfg_high),
        .stb_low  (pg_low),
        .sample   (pg_sample),
        .done     (pg_done)
    );

    nbs_delay #(.TW(TW)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dl_start),
        .dly     (cfg_wait),
        .expired (dl_exp)
    );

    // Main request sequencer: opcode, addresses, settle, ready, data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            issued   <= 1'b0;
            cmd_q    <= '0;
            addr_q   <= '0;
            acnt_q   <= '0;
            aidx     <= '0;
            len_q    <= '0;
            dcnt     <= '0;
            rd_q     <= 1'b0;
            prog_q   <= 1'b0;
            dout_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            if (pg_start) begin
                issued <= 1'b1;
                if (!rd_phase) dout_q <= byte_sel;
            end
            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        cmd_q  <= req_cmd;
                        addr_q <= req_addr;
                        acnt_q <= req_addr_cnt;
                        len_q  <= req_len;
                        rd_q   <= req_rd;
                        prog_q <= req_prog;
                        aidx   <= '0;
                        dcnt   <= '0;
                        issued <= 1'b0;
                        st     <= SQ_CMD;
                    end
                end
                SQ_CMD: begin
                    if (pg_done) begin
                        issued <= 1'b0;
                        st     <= (acnt_q != '0) ? SQ_ADDR : SQ_DLY;
                    end
                end
                SQ_ADDR: begin
                    if (pg_done) begin
                        issued <= 1'b0;
                        aidx   <= aidx + 1'b1;
                        if (aidx == acnt_q - 1'b1) st <= SQ_DLY;
                    end
                end
                SQ_DLY: begin
                    if (dl_start) issued <= 1'b1;
                    if (dl_exp) begin
                        issued <= 1'b0;
                        st     <= SQ_RDY;
                    end
                end
                SQ_RDY: begin
                    if (ready_s) st <= (len_q == '0) ? SQ_FIN : SQ_DATA;
                end
                SQ_DATA: begin
                    if (pg_sample && rd_q) begin
                        rd_data  <= fl_din;
                        rd_valid <= 1'b1;
                    end
                    if (pg_done) begin
                        issued <= 1'b0;
                        dcnt   <= dcnt + 1'b1;
                        if (dcnt == len_q - 1'b1) st <= SQ_FIN;
                    end
                end
                SQ_FIN: begin
                    done <= 1'b1;
                    st   <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign req_ready   = (st == SQ_IDLE);
    assign fl_sel_n    = (st == SQ_IDLE);
    assign fl_cmd_lat  = (st == SQ_CMD);
    assign fl_adr_lat  = (st == SQ_ADDR);
    assign fl_doe      = (st == SQ_CMD) || (st == SQ_ADDR) || ((st == SQ_DATA) && !rd_q);
    assign fl_wr_stb_n = !(pg_low && !rd_phase);
    assign fl_rd_stb_n = !(pg_low && rd_phase);
    assign fl_lock_n   = (st != SQ_IDLE) && prog_q;
    assign fl_dout     = dout_q;

endmodule

// File: rtl/nbs_checker.sv
// Protocol checker for nandbus_seq, attached with bind.
// Assumes: observes only the top-level ports.
module nbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       fl_sel_n,
    input logic       fl_cmd_lat,
    input logic       fl_adr_lat,
    input logic       fl_wr_stb_n,
    input logic       fl_rd_stb_n,
    input logic       fl_lock_n,
    input logic [7:0] fl_dout,
    input logic       fl_doe
);

    AST_SEL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_wr_stb_n || !fl_rd_stb_n) |-> !fl_sel_n); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_sel_n && fl_wr_stb_n && fl_rd_stb_n && !fl_doe)); // R1
    AST_QUAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cmd_lat && fl_adr_lat)); // R2
    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_wr_stb_n && $past(!fl_wr_stb_n)) |->
        ($stable(fl_dout) && $stable(fl_cmd_lat) && $stable(fl_adr_lat))); // R3
    AST_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_wr_stb_n) |-> ($stable(fl_dout) && $stable(fl_cmd_lat) && $stable(fl_adr_lat))); // R3
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_wr_stb_n && !fl_rd_stb_n)); // R5
    AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rd_stb_n |-> (!fl_doe && !fl_cmd_lat && !fl_adr_lat)); // R6
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_wr_stb_n |-> fl_doe); // R6
    AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !fl_lock_n); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

bind nandbus_seq nbs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .done        (done),
    .fl_sel_n    (fl_sel_n),
    .fl_cmd_lat  (fl_cmd_lat),
    .fl_adr_lat  (fl_adr_lat),
    .fl_wr_stb_n (fl_wr_stb_n),
    .fl_rd_stb_n (fl_rd_stb_n),
    .fl_lock_n   (fl_lock_n),
    .fl_dout     (fl_dout),
    .fl_doe      (fl_doe)
);

// File: tb/nandbus_seq_tb_top.sv
// Testbench for nandbus_seq with a behavioural device model.
module nandbus_seq_tb_top;

    localparam int BUSY_T = 25;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [2:0]  acnt;
        logic [39:0] addr;
        logic [11:0] len;
        logic        rd;
        logic        prog;
        logic [3:0]  lo;
        logic [3:0]  hi;
        logic [3:0]  wt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'hFF, 3'd0, 40'h0,          12'd0, 1'b0, 1'b0, 4'd1, 4'd1, 4'd1},
        '{8'h90, 3'd1, 40'h0000000020, 12'd4, 1'b1, 1'b0, 4'd2, 4'd1, 4'd2},
        '{8'h80, 3'd5, 40'h5544332211, 12'd6, 1'b0, 1'b1, 4'd3, 4'd2, 4'd3},
        '{8'h60, 3'd3, 40'h0000C0B0A0, 12'd0, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0},
        '{8'h00, 3'd5, 40'h0908070605, 12'd3, 1'b1, 1'b0, 4'd1, 4'd3, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = '0;
    logic [2:0]  req_addr_cnt = '0;
    logic [39:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        req_rd = 1'b0;
    logic        req_prog = 1'b0;
    logic [3:0]  cfg_low = 4'd1, cfg_high = 4'd1, cfg_wait = 4'd1;
    logic [7:0]  wr_data;
    logic        wr_take;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done;
    logic        fl_sel_n, fl_cmd_lat, fl_adr_lat, fl_wr_stb_n, fl_rd_stb_n, fl_lock_n;
    logic [7:0]  fl_dout;
    logic        fl_doe;
    logic [7:0]  fl_din;
    logic        fl_ready;

    int nchk = 0, nerr = 0, cyc = 0;
    int widx = 0;
    logic wclr = 1'b0, mclr = 1'b0;
    int exp_lo = 1, exp_hi = 1;
    logic prog_cur = 1'b0;

    // Device model state.
    int busy_cnt = 0, ridx = 0, ncap = 0, nr = 0;
    int lowbad = 0, highbad = 0, viol = 0, lockbad = 0, oebad = 0, selbad = 0;
    int lo_cnt = 0, hi_cnt = 0;
    logic have_prev = 1'b0, prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] cap_b [64];
    logic [1:0] cap_k [64];
    logic [7:0] rcap [64];

    always #4 clk = ~clk;

    function automatic logic [7:0] wpat(input int i);
        return 8'(8'h3C + i * 7);
    endfunction
    function automatic logic [7:0] rpat(input int i);
        return 8'(8'hC3 ^ (i * 5));
    endfunction

    assign wr_data  = wpat(widx);
    assign fl_din   = fl_rd_stb_n ? 8'h00 : rpat(ridx);
    assign fl_ready = (busy_cnt == 0);

    nandbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr_cnt(req_addr_cnt), .req_addr(req_addr),
        .req_len(req_len), .req_rd(req_rd), .req_prog(req_prog),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_wait(cfg_wait),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .fl_sel_n(fl_sel_n), .fl_cmd_lat(fl_cmd_lat), .fl_adr_lat(fl_adr_lat),
        .fl_wr_stb_n(fl_wr_stb_n), .fl_rd_stb_n(fl_rd_stb_n), .fl_lock_n(fl_lock_n),
        .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din), .fl_ready(fl_ready)
    );

    // Host write-data source: advance after each consumed byte.
    always @(posedge clk) begin
        if (wclr)         widx <= 0;
        else if (wr_take) widx <= widx + 1;
    end

    // Device model and bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mclr) begin
            ncap = 0; nr = 0; ridx = 0; lowbad = 0; highbad = 0; viol = 0;
            lockbad = 0; oebad = 0; selbad = 0; lo_cnt = 0; hi_cnt = 0;
            have_prev = 1'b0; prev_we = 1'b1; prev_re = 1'b1;
        end else if (rst_n) begin
            if (!prev_we && fl_wr_stb_n) begin
                if (ncap < 64) begin
                    cap_b[ncap] = fl_dout;
                    cap_k[ncap] = {fl_cmd_lat, fl_adr_lat};
                end
                ncap++;
                if (lo_cnt != exp_lo) lowbad++;
                lo_cnt = 0;
                if (fl_sel_n) selbad++;
                if (fl_cmd_lat || fl_adr_lat) busy_cnt = BUSY_T;
            end
            if (!prev_re && fl_rd_stb_n) begin
                ridx++;
                if (lo_cnt != exp_lo) lowbad++;
                lo_cnt = 0;
            end
            if ((prev_we && !fl_wr_stb_n) || (prev_re && !fl_rd_stb_n)) begin
                if (have_prev && hi_cnt < exp_hi) highbad++;
                have_prev = 1'b1;
                if (!fl_rd_stb_n && fl_doe) oebad++;
                if (busy_cnt > 0 && !fl_cmd_lat && !fl_adr_lat) viol++;
            end
            if (!fl_wr_stb_n || !fl_rd_stb_n) begin lo_cnt++; hi_cnt = 0; end
            else hi_cnt++;
            if (fl_lock_n != (!fl_sel_n && prog_cur)) lockbad++;
            if (done && busy_cnt > 0) viol++;
            if (rd_valid) begin
                if (nr < 64) rcap[nr] = rd_data;
                nr++;
            end
            prev_we = fl_wr_stb_n;
            prev_re = fl_rd_stb_n;
        end
        if (busy_cnt > 0) busy_cnt--;
    end

    // Global watchdog: a hung run ends as a failure with the summary line.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_monitor();
        mclr = 1'b1; wclr = 1'b1;
        repeat (2) @(negedge clk);
        mclr = 1'b0; wclr = 1'b0;
    endtask

    // Run one request; optionally poke a stray request mid-transfer (R10).
    task automatic run_op(input vec_t v, input bit poke);
        bit got;
        int nexp;
        clear_monitor();
        exp_lo   = (v.lo == 0) ? 1 : int'(v.lo);
        exp_hi   = (v.hi == 0) ? 1 : int'(v.hi);
        prog_cur = v.prog;
        req_cmd = v.cmd; req_addr_cnt = v.acnt; req_addr = v.addr; req_len = v.len;
        req_rd = v.rd; req_prog = v.prog; cfg_low = v.lo; cfg_high = v.hi; cfg_wait = v.wt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (done) begin got = 1'b1; break; end
            if (poke && k == 5) begin req_valid = 1'b1; req_cmd = 8'hEE; end
            if (poke && k == 6) begin req_valid = 1'b0; req_cmd = v.cmd; end
            @(negedge clk);
        end
        chk(got, "R10 done pulse seen", int'(got), 1);
        chk(req_ready, "R10 ready with done", int'(req_ready), 1);
        repeat (3) @(negedge clk);
        nexp = 1 + int'(v.acnt) + (v.rd ? 0 : int'(v.len));
        chk(ncap == nexp, "R2 write pulse count", ncap, nexp);
        chk(cap_k[0] == 2'b10 && cap_b[0] == v.cmd, "R2 opcode first", int'(cap_b[0]), int'(v.cmd));
        for (int i = 0; i < int'(v.acnt); i++)
            chk(cap_k[1+i] == 2'b01 && cap_b[1+i] == v.addr[i*8 +: 8], "R2 address byte",
                int'(cap_b[1+i]), int'(v.addr[i*8 +: 8]));
        if (!v.rd) begin
            for (int i = 0; i < int'(v.len); i++)
                chk(cap_k[1+int'(v.acnt)+i] == 2'b00 && cap_b[1+int'(v.acnt)+i] == wpat(i),
                    "R4 write data byte", int'(cap_b[1+int'(v.acnt)+i]), int'(wpat(i)));
            chk(widx == int'(v.len), "R4 take pulses", widx, int'(v.len));
        end else begin
            chk(nr == int'(v.len), "R5 read byte count", nr, int'(v.len));
            for (int i = 0; i < int'(v.len); i++)
                chk(rcap[i] == rpat(i), "R5 read data byte", int'(rcap[i]), int'(rpat(i)));
        end
        chk(lowbad == 0, "R9 low time", lowbad, 0);
        chk(highbad == 0, "R9 high time", highbad, 0);
        chk(viol == 0, "R7 data or done while busy", viol, 0);
        chk(lockbad == 0, "R8 write protect", lockbad, 0);
        chk(oebad == 0, "R6 bus released on read", oebad, 0);
        chk(selbad == 0, "R1 select during pulse", selbad, 0);
        chk(fl_sel_n, "R1 deselect after request", int'(fl_sel_n), 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(ncap == nexp, "R10 stray request ignored", ncap, nexp);
            chk(fl_sel_n && req_ready, "R10 stays idle", int'(fl_sel_n), 1);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(req_ready && fl_sel_n && fl_wr_stb_n && fl_rd_stb_n && !fl_doe,
            tag, int'({req_ready, fl_sel_n, fl_wr_stb_n, fl_rd_stb_n, fl_doe}), 5'b11110);
        chk(!fl_lock_n, "R8 protected when idle", int'(fl_lock_n), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset state");
        // Table of requests walked by one loop.
        for (int i = 0; i < 5; i++) run_op(VECS[i], 1'b0);
        // Stray request during a program transfer (R10).
        run_op(VECS[2], 1'b1);
        // Reset in the middle of a read (R1).
        req_cmd = 8'h00; req_addr_cnt = 3'd2; req_addr = 40'h0201; req_len = 12'd3;
        req_rd = 1'b1; req_prog = 1'b1; cfg_low = 4'd2; cfg_high = 4'd2; cfg_wait = 4'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(!fl_sel_n && fl_lock_n, "R8 released during program", int'(fl_lock_n), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R1 idle after mid reset");
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        run_op(VECS[1], 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule